// File: doc/BRIEF.md
# Code-Selected Synthesizer Reference Divider

This block divides the crystal-derived clock of a frequency synthesizer down to the comparison reference used by the phase detector. A 4-bit selection code picks one of eight reference rates between 1 kHz and 25 kHz. Several codes are aliases of the same rate. Two reserved codes put the loop into an inhibit state. While inhibit is active, the surrounding chip pulls the RF divider inputs to ground and floats the charge pump. One of the two reserved codes also requests that the crystal oscillator stop.

The crystal frequency is the parameter `XTAL_HZ`. Every divide ratio is computed from it as `XTAL_HZ / f_ref`, so `XTAL_HZ` must be a multiple of 75 kHz. The output `ref_pulse` is a one-clock pulse that repeats once per divide period. A code change never shortens or stretches the period already in progress: the new ratio is loaded at the next terminal count. The two flags are registered levels that follow the code one clock later.

Top module: `refdiv_top`

## Requirements
- R1: While `rst` is high at a clock edge, all three outputs read 0 after that edge.
- R2: Codes 0 through 3 give a `ref_pulse` period of `XTAL_HZ/25000` clocks.
- R3: Code 4 gives `XTAL_HZ/12500` clocks, code 5 gives `XTAL_HZ/6250`, and codes 6 and 7 give `XTAL_HZ/3125`.
- R4: Codes 8 to 10 give `XTAL_HZ/5000` clocks, code 11 gives `XTAL_HZ/1000`, code 12 gives `XTAL_HZ/3000`, and code 13 gives `XTAL_HZ/15000`.
- R5: Each `ref_pulse` is high for exactly one clock.
- R6: Code 14 (4'b1110) sets both `pll_inhibit` and `osc_stop` one clock after it is applied. `osc_stop` stays high for as long as the code is held, and `osc_stop` is never high without `pll_inhibit`.
- R7: Code 15 (4'b1111) sets `pll_inhibit` one clock after it is applied, with `osc_stop` low.
- R8: No `ref_pulse` occurs while `pll_inhibit` is high.
- R9: A change between non-inhibit codes in mid-period lets the current period finish at its old length. The following period uses the new ratio.
- R10: On leaving inhibit, `ref_pulse` is high in the same cycle in which `pll_inhibit` falls, which is one clock after the non-inhibit code is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived clock at `XTAL_HZ` |
| rst | input | 1 | Synchronous reset, active high |
| ref_sel | input | 4 | Reference rate selection code |
| ref_pulse | output | 1 | One-clock reference pulse, one per divide period |
| pll_inhibit | output | 1 | Loop inhibit flag (codes 14 and 15) |
| osc_stop | output | 1 | Oscillator stop request (code 14 only) |

## Verification
The bench builds the block with `XTAL_HZ` set to 75000, the smallest crystal rate that divides evenly into every reference rate. At that rate the ratios fall to between 3 and 75 clocks, so all sixteen codes can be measured period by period in a few thousand cycles. The short ratios also keep the mid-period switch between the longest (75) and shortest (3, 5) ratios cheap to time exactly. The same RTL elaborates at its default megahertz-range crystal, where only the counter width grows.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  typedef logic [3:0] ref_code_t;

  localparam ref_code_t CODE_INH_STOP = 4'hE;
  localparam ref_code_t CODE_INH_ONLY = 4'hF;

  // Reference rate in Hz for a code; 0 marks an inhibit code.
  function automatic int unsigned ref_hz(input ref_code_t c);
    case (c)
      4'h0, 4'h1, 4'h2, 4'h3: ref_hz = 25000;
      4'h4:                   ref_hz = 12500;
      4'h5:                   ref_hz = 6250;
      4'h6, 4'h7:             ref_hz = 3125;
      4'h8, 4'h9, 4'hA:       ref_hz = 5000;
      4'hB:                   ref_hz = 1000;
      4'hC:                   ref_hz = 3000;
      4'hD:                   ref_hz = 15000;
      default:                ref_hz = 0;
    endcase
  endfunction

  function automatic bit code_inhibits(input ref_code_t c);
    return (c == CODE_INH_STOP) || (c == CODE_INH_ONLY);
  endfunction

  // Divide ratio in clocks; inhibit codes yield 1 (never used).
  function automatic int unsigned ratio_for(input int unsigned xtal, input ref_code_t c);
    int unsigned hz;
    hz = ref_hz(c);
    return (hz == 0) ? 1 : xtal / hz;
  endfunction

  function automatic int unsigned max_ratio(input int unsigned xtal);
    int unsigned m;
    m = 1;
    for (int i = 0; i < 16; i++) begin
      if (ratio_for(xtal, ref_code_t'(i)) > m) m = ratio_for(xtal, ref_code_t'(i));
    end
    return m;
  endfunction

endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
  import refdiv_pkg::*;
#(
  parameter int unsigned XTAL_HZ = 7_200_000,
  parameter int unsigned CW      = 13
) (
  input  ref_code_t         code,
  output logic [CW-1:0]     reload_val,
  output logic              inhibit_req,
  output logic              stop_req
);

  localparam int NCODES = 16;

  logic [CW-1:0] reload_tbl [NCODES];

  // One terminal-count entry per code, computed from the crystal rate.
  for (genvar g = 0; g < NCODES; g++) begin : g_tbl
    localparam int unsigned RATIO = ratio_for(XTAL_HZ, ref_code_t'(g));
    assign reload_tbl[g] = CW'(RATIO - 1);
  end

  assign reload_val  = reload_tbl[code];
  assign inhibit_req = code_inhibits(code);
  assign stop_req    = (code == CODE_INH_STOP);

endmodule

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ref_code_t code,
  input  logic      inhibit_req,
  input  logic      stop_req,
  output logic      inhibit_q,
  output logic      stop_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      inhibit_q <= 1'b0;
      stop_q    <= 1'b0;
    end else begin
      inhibit_q <= inhibit_req;
      stop_q    <= stop_req;
    end
  end

  // R6: oscillator stop is only requested together with inhibit
  p_stop_needs_inhibit_r6: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> inhibit_q);

  // R6: holding the stop code keeps the level asserted
  p_stop_level_r6: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_INH_STOP) |=> (stop_q && inhibit_q));

  // R7: the plain inhibit code never requests an oscillator stop
  p_inhibit_only_r7: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_INH_ONLY) |=> (inhibit_q && !stop_q));

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int unsigned CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [CW-1:0] reload_val,
  output logic          pulse,
  output logic          at_terminal
);

  logic [CW-1:0] cnt;

  assign at_terminal = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (hold) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= at_terminal;
      cnt   <= at_terminal ? reload_val : cnt - 1'b1;
    end
  end

  // R5: pulses are a single clock wide (every ratio is at least 3)
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R9: mid-period the count only moves down, so a new code cannot cut a period short
  p_no_midperiod_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (!hold && !at_terminal) |=> (cnt < $past(cnt)));

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int unsigned XTAL_HZ = 7_200_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] ref_sel,
  output logic       ref_pulse,
  output logic       pll_inhibit,
  output logic       osc_stop
);

  localparam int unsigned MAXDIV = max_ratio(XTAL_HZ);
  localparam int unsigned CW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

  logic [CW-1:0] reload_val;
  logic          inhibit_req;
  logic          stop_req;
  logic          at_terminal;

  refdiv_decode #(.XTAL_HZ(XTAL_HZ), .CW(CW)) u_decode (
    .code        (ref_sel),
    .reload_val  (reload_val),
    .inhibit_req (inhibit_req),
    .stop_req    (stop_req)
  );

  refdiv_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .code        (ref_sel),
    .inhibit_req (inhibit_req),
    .stop_req    (stop_req),
    .inhibit_q   (pll_inhibit),
    .stop_q      (osc_stop)
  );

  refdiv_counter #(.CW(CW)) u_counter (
    .clk         (clk),
    .rst         (rst),
    .hold        (inhibit_req),
    .reload_val  (reload_val),
    .pulse       (ref_pulse),
    .at_terminal (at_terminal)
  );

  // R8: the reference is silent while the loop is inhibited
  p_quiet_inhibit_r8: assert property (@(posedge clk) disable iff (rst)
    pll_inhibit |-> !ref_pulse);

  // R10: release from inhibit produces an immediate first pulse
  p_release_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_inhibit) |-> ref_pulse);

  // R10: an inhibit stretch leaves the counter parked at terminal count
  p_parked_r10: assert property (@(posedge clk) disable iff (rst)
    pll_inhibit |-> at_terminal);

endmodule

// File: tb/sim_refdiv_top.sv
module sim_refdiv_top;

  localparam int unsigned XTAL = 75000;
  // Expected ratio per code at a 75 kHz crystal; 0 = inhibit code.
  localparam int VEC_DIV  [16] = '{3, 3, 3, 3, 6, 12, 24, 24, 15, 15, 15, 75, 25, 5, 0, 0};
  localparam bit VEC_STOP [16] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ref_sel = 4'h0;
  logic       ref_pulse, pll_inhibit, osc_stop;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  refdiv_top #(.XTAL_HZ(XTAL)) u0 (
    .clk         (clk),
    .rst         (rst),
    .ref_sel     (ref_sel),
    .ref_pulse   (ref_pulse),
    .pll_inhibit (pll_inhibit),
    .osc_stop    (osc_stop)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic find_pulse(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ref_pulse) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic next_gap(output int gap);
    gap = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      gap++;
      if (ref_pulse) break;
    end
  endtask

  function automatic string req_of(input int code);
    if (code < 4)  return "R2";
    if (code < 8)  return "R3";
    if (code < 14) return "R4";
    if (code == 14) return "R6";
    return "R7";
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit seen;
    int gap;
    int npulse;
    bit stop_ok;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!ref_pulse && !pll_inhibit && !osc_stop, "R1", "outputs in reset",
          {ref_pulse, pll_inhibit, osc_stop}, 0);
    rst = 1'b0;

    // Table walk over every code
    for (int code = 0; code < 16; code++) begin
      @(negedge clk);
      ref_sel = 4'(code);
      repeat (160) @(negedge clk);
      if (VEC_DIV[code] == 0) begin
        check(pll_inhibit == 1'b1, req_of(code), "inhibit flag", pll_inhibit, 1);
        check(osc_stop == VEC_STOP[code], req_of(code), "stop flag", osc_stop, VEC_STOP[code]);
        npulse = 0;
        for (int i = 0; i < 100; i++) begin
          @(negedge clk);
          if (ref_pulse) npulse++;
        end
        check(npulse == 0, "R8", "pulses while inhibited", npulse, 0);
      end else begin
        check(!pll_inhibit && !osc_stop, req_of(code), "flags clear",
              {pll_inhibit, osc_stop}, 0);
        find_pulse(seen);
        check(seen, req_of(code), "pulse present", seen, 1);
        @(negedge clk);
        check(!ref_pulse, "R5", "pulse width", ref_pulse, 0);
        next_gap(gap);
        gap++;
        check(gap == VEC_DIV[code], req_of(code), "period", gap, VEC_DIV[code]);
      end
    end

    // R9: switch from the longest to a short ratio mid-period
    @(negedge clk);
    ref_sel = 4'hB;
    repeat (160) @(negedge clk);
    find_pulse(seen);
    repeat (10) @(negedge clk);
    ref_sel = 4'hD;
    next_gap(gap);
    check(gap == 65, "R9", "old period completes", gap + 10, 75);
    next_gap(gap);
    check(gap == 5, "R9", "new period applies", gap, 5);

    // R9: switch from short to long ratio, period in progress unchanged
    find_pulse(seen);
    @(negedge clk);
    ref_sel = 4'h4;
    next_gap(gap);
    check(gap == 4, "R9", "short period completes", gap + 1, 5);
    next_gap(gap);
    check(gap == 6, "R9", "long period applies", gap, 6);

    // R6: stop code timing and level hold
    @(negedge clk);
    ref_sel = 4'hE;
    @(negedge clk);
    check(pll_inhibit && osc_stop, "R6", "flags one clock after code",
          {pll_inhibit, osc_stop}, 3);
    stop_ok = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!osc_stop || !pll_inhibit || ref_pulse) stop_ok = 1'b0;
    end
    check(stop_ok, "R6", "stop level held, no pulses", stop_ok, 1);

    // R7: stop code to plain inhibit drops only the stop request
    ref_sel = 4'hF;
    @(negedge clk);
    check(pll_inhibit && !osc_stop, "R7", "inhibit without stop",
          {pll_inhibit, osc_stop}, 2);

    // R10: release gives a pulse with the falling inhibit flag
    repeat (5) @(negedge clk);
    ref_sel = 4'h2;
    @(negedge clk);
    check(!pll_inhibit && ref_pulse, "R10", "first pulse on release",
          {pll_inhibit, ref_pulse}, 1);
    next_gap(gap);
    check(gap == 3, "R10", "period after release", gap, 3);

    // R1: reset in mid-operation
    @(negedge clk);
    ref_sel = 4'hE;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!ref_pulse && !pll_inhibit && !osc_stop, "R1", "outputs after reset",
          {ref_pulse, pll_inhibit, osc_stop}, 0);
    ref_sel = 4'h0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ref_pulse, "R1", "first pulse after reset release", ref_pulse, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule